// File: doc/BRIEF.md
# Integer Register-Execute Unit

This block runs the register-to-register and register-immediate arithmetic of a 32-bit load/store machine. Each cycle it may accept one instruction word, qualified by a valid strobe. The word is split into its fields and the two source registers are read from a 32 x 32-bit register file. The unit computes the result and writes it back into that file on the next clock edge.

Two encodings are decoded. The register form carries the opcode in bits 31:26, the first source in 25:21, the second source in 20:16, the destination in 15:11, a shift amount in 10:6 and a function code in 5:0. The immediate form keeps the same opcode and first-source fields, uses bits 20:16 as the destination and bits 15:0 as a 16-bit constant.

An extra read port lets a debugger or a neighbouring block inspect any register. The read is combinational. Memory access, control transfer and traps are handled elsewhere. Any encoding the unit does not recognise leaves the register file unchanged.

Top module: `int_reg_exec`

## Requirements
- R1: Register index 0 always reads as zero. A write aimed at index 0, from either encoding, is dropped.
- R2: Opcode 0 with function code 32 writes the wrapped 32-bit sum of the two source registers into the field in bits 15:11.
- R3: Opcode 0 with function code 34 writes the wrapped difference (first source minus second) into bits 15:11.
- R4: Opcode 0 with function code 42 writes 1 when the first source is below the second as a signed two's-complement value, and 0 otherwise.
- R5: Opcode 8 writes the first source plus the sign-extended bits 15:0 into the register named by bits 20:16. The sum wraps.
- R6: Opcode 10 writes 1 into bits 20:16 when the first source is below the sign-extended constant as a signed value, and 0 otherwise.
- R7: Opcode 12 writes the bitwise AND of the first source and the zero-extended constant into bits 20:16.
- R8: Opcode 13 writes the bitwise OR of the first source and the zero-extended constant into bits 20:16.
- R9: Opcode 15 writes the constant into bits 31:16 of the register named by bits 20:16 and clears bits 15:0.
- R10: No register changes for an unlisted opcode, for opcode 0 with an unlisted function code, or for any word presented while the valid strobe is low.
- R11: A result lands in the register file on the clock edge that samples its valid instruction. An instruction issued in the very next cycle that reads that register uses the new value.
- R12: Reset clears every register to zero. The debug port returns the current content of whichever register its index selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Qualifies instr_word for this cycle |
| instr_word | input | 32 | Instruction to execute |
| dbg_idx | input | 5 | Register selected for inspection |
| dbg_val | output | XLEN (32) | Content of the selected register |

## Verification
The clocked properties assume that instr_valid, instr_word and dbg_idx hold known values at every sampled edge once reset is released. They also assume that reset is applied before the first instruction. The stimulus meets both conditions. It sets all inputs to defined values before reset is released. It drives new values only on the falling edge, and it pulls the valid strobe low again after each accepted instruction. Deliberately invalid words are sent with fully known bits, so the no-write properties are tested on real encodings rather than on unknown values.

// File: rtl/rix_pkg.sv
package rix_pkg;
    localparam int INSN_W = 32;
    localparam int OPC_W  = 6;
    localparam int REG_AW = 5;
    localparam int IMM_W  = 16;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_AND,
        ALU_OR,
        ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_REG,
        SRC_SEXT,
        SRC_ZEXT
    } opb_src_e;

    typedef struct packed {
        logic              wr_en;
        logic [REG_AW-1:0] wr_idx;
        logic [REG_AW-1:0] rs_idx;
        logic [REG_AW-1:0] rt_idx;
        alu_op_e           op;
        opb_src_e          bsrc;
        logic [IMM_W-1:0]  imm;
    } uop_t;
endpackage

// File: rtl/rix_decode.sv
module rix_decode
    import rix_pkg::*;
(
    input  logic              instr_valid,
    input  logic [INSN_W-1:0] instr_word,
    output uop_t              uop
);
    logic [OPC_W-1:0] opc;
    logic [5:0]       funct;
    logic             shamt_unused;

    assign opc          = instr_word[31:26];
    assign funct        = instr_word[5:0];
    assign shamt_unused = ^instr_word[10:6];

    always_comb begin
        uop        = '0;
        uop.rs_idx = instr_word[25:21];
        uop.rt_idx = instr_word[20:16];
        uop.imm    = instr_word[15:0];
        uop.op     = ALU_ADD;
        uop.bsrc   = SRC_REG;
        uop.wr_idx = instr_word[20:16];
        if (instr_valid) begin
            unique case (opc)
                OPC_RTYPE: begin
                    uop.wr_idx = instr_word[15:11];
                    unique case (funct)
                        FN_ADD:  begin uop.wr_en = 1'b1; uop.op = ALU_ADD; end
                        FN_SUB:  begin uop.wr_en = 1'b1; uop.op = ALU_SUB; end
                        FN_SLT:  begin uop.wr_en = 1'b1; uop.op = ALU_SLT; end
                        default: uop.wr_en = 1'b0;
                    endcase
                end
                OPC_ADDI: begin
                    uop.wr_en = 1'b1; uop.op = ALU_ADD; uop.bsrc = SRC_SEXT;
                end
                OPC_SLTI: begin
                    uop.wr_en = 1'b1; uop.op = ALU_SLT; uop.bsrc = SRC_SEXT;
                end
                OPC_ANDI: begin
                    uop.wr_en = 1'b1; uop.op = ALU_AND; uop.bsrc = SRC_ZEXT;
                end
                OPC_ORI: begin
                    uop.wr_en = 1'b1; uop.op = ALU_OR; uop.bsrc = SRC_ZEXT;
                end
                OPC_LUI: begin
                    uop.wr_en = 1'b1; uop.op = ALU_LUI; uop.bsrc = SRC_ZEXT;
                end
                default: uop.wr_en = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rix_alu.sv
module rix_alu
    import rix_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e          op,
    input  opb_src_e         bsrc,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  reg_b,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  result
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] opb;
    logic            lt_signed;

    always_comb begin
        unique case (bsrc)
            SRC_REG:  opb = reg_b;
            SRC_SEXT: opb = {{EXT_W{imm[IMM_W-1]}}, imm};
            SRC_ZEXT: opb = {{EXT_W{1'b0}}, imm};
            default:  opb = reg_b;
        endcase
    end

    assign lt_signed = $signed(opa) < $signed(opb);

    always_comb begin
        unique case (op)
            ALU_ADD: result = opa + opb;
            ALU_SUB: result = opa - opb;
            ALU_SLT: result = {{(XLEN-1){1'b0}}, lt_signed};
            ALU_AND: result = opa & opb;
            ALU_OR:  result = opa | opb;
            ALU_LUI: result = {imm, {EXT_W{1'b0}}};
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/rix_regfile.sv
module rix_regfile #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]    rd_addr,
    output logic [NRD-1:0][XLEN-1:0]  rd_data
);
    logic [NREG-1:0][XLEN-1:0] regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (we && waddr != '0) begin
            regs_q[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = (rd_addr[g] == '0) ? '0 : regs_q[rd_addr[g]];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> regs_q[$past(waddr)] == $past(wdata)); // R11

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_q)); // R10

    AST_ZERO_SLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> regs_q[0] == '0); // R1
endmodule

// File: rtl/int_reg_exec.sv
module int_reg_exec
    import rix_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [INSN_W-1:0] instr_word,
    input  logic [REG_AW-1:0] dbg_idx,
    output logic [XLEN-1:0]   dbg_val
);
    localparam int RF_DEPTH = 1 << REG_AW;
    localparam int RD_PORTS = 3;
    localparam int P_RS     = 0;
    localparam int P_RT     = 1;
    localparam int P_DBG    = 2;

    uop_t                              uop;
    logic [RD_PORTS-1:0][REG_AW-1:0]   rd_idx;
    logic [RD_PORTS-1:0][XLEN-1:0]     rd_val;
    logic [XLEN-1:0]                   alu_y;

    rix_decode u_decode (
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .uop         (uop)
    );

    assign rd_idx[P_RS]  = uop.rs_idx;
    assign rd_idx[P_RT]  = uop.rt_idx;
    assign rd_idx[P_DBG] = dbg_idx;

    rix_regfile #(
        .XLEN (XLEN),
        .NREG (RF_DEPTH),
        .NRD  (RD_PORTS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (uop.wr_en),
        .waddr   (uop.wr_idx),
        .wdata   (alu_y),
        .rd_addr (rd_idx),
        .rd_data (rd_val)
    );

    rix_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .op     (uop.op),
        .bsrc   (uop.bsrc),
        .opa    (rd_val[P_RS]),
        .reg_b  (rd_val[P_RT]),
        .imm    (uop.imm),
        .result (alu_y)
    );

    assign dbg_val = rd_val[P_DBG];

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !uop.wr_en); // R10

    AST_ZERO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_idx == '0 |-> dbg_val == '0); // R1

    AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (uop.wr_en && uop.op == ALU_SLT) |-> alu_y[XLEN-1:1] == '0); // R4

    AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (uop.wr_en && uop.op == ALU_LUI) |-> alu_y[IMM_W-1:0] == '0); // R9

    AST_DBG_SEES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (uop.wr_en && uop.wr_idx != '0 && dbg_idx == uop.wr_idx) |=>
        ($stable(dbg_idx) -> dbg_val == $past(alu_y))); // R12
endmodule

// File: tb/int_reg_exec_tb.sv
`timescale 1ns/1ps
module int_reg_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [4:0]  dbg_idx = '0;
    logic [31:0] dbg_val;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] model [32];

    typedef struct {
        logic [4:0]  r;
        logic [31:0] v;
        string       t;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    int_reg_exec u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .dbg_idx     (dbg_idx),
        .dbg_val     (dbg_val)
    );

    function automatic logic [31:0] r_ins(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] i_ins(int op, int rs, int rt, logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [4:0] dest_of(logic [31:0] w);
        return (w[31:26] == 6'd0) ? w[15:11] : w[20:16];
    endfunction

    // Reference behaviour taken from R1..R10
    task automatic model_step(logic [31:0] w, logic v);
        logic [31:0] a, b, sx, zx, res;
        bit wr;
        wr  = 1'b0;
        res = '0;
        a   = model[w[25:21]];
        b   = model[w[20:16]];
        sx  = {{16{w[15]}}, w[15:0]};
        zx  = {16'd0, w[15:0]};
        if (v) begin
            case (w[31:26])
                6'd0: case (w[5:0])
                    6'd32: begin wr = 1; res = a + b; end
                    6'd34: begin wr = 1; res = a - b; end
                    6'd42: begin wr = 1; res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; end
                    default: wr = 0;
                endcase
                6'd8:  begin wr = 1; res = a + sx; end
                6'd10: begin wr = 1; res = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; end
                6'd12: begin wr = 1; res = a & zx; end
                6'd13: begin wr = 1; res = a | zx; end
                6'd15: begin wr = 1; res = {w[15:0], 16'd0}; end
                default: wr = 0;
            endcase
        end
        if (wr && dest_of(w) != 5'd0) model[dest_of(w)] = res;
    endtask

    task automatic expect_reg(logic [4:0] r, string tag);
        item_t it;
        it.r = r; it.v = model[r]; it.t = tag;
        sb_q.push_back(it);
    endtask

    // Driver: present one word for one cycle, then queue the register it targets
    task automatic issue(logic [31:0] w, logic v, string tag);
        @(negedge clk);
        instr_word  = w;
        instr_valid = v;
        model_step(w, v);
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
        expect_reg(dest_of(w), tag);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        #2;
    endtask

    // Monitor: one comparison per falling edge, before the next write edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                dbg_idx = it.r;
                #1;
                n_checks++;
                if (dbg_val !== it.v) begin
                    n_fails++;
                    $display("FAIL %s: reg %0d actual %h expected %h", it.t, it.r, dbg_val, it.v);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R11: watchdog actual hung expected complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: every register cleared by reset
        for (int i = 0; i < 32; i++) expect_reg(5'(i), "R12");
        drain();

        issue(i_ins(15, 0, 1, 16'h1234), 1, "R9");
        issue(i_ins(13, 1, 1, 16'h8765), 1, "R11");      // reads r1 written one cycle earlier
        issue(i_ins(8, 0, 2, 16'hFFFF), 1, "R5");         // -1
        issue(i_ins(8, 0, 3, 16'h7FFF), 1, "R5");
        issue(r_ins(1, 2, 4, 32), 1, "R2");
        issue(i_ins(15, 0, 5, 16'h7FFF), 1, "R9");
        issue(i_ins(13, 5, 5, 16'hFFFF), 1, "R8");
        issue(i_ins(8, 0, 6, 16'h0001), 1, "R5");
        issue(r_ins(5, 6, 7, 32), 1, "R2");               // wraps to 0x80000000
        issue(r_ins(0, 6, 8, 34), 1, "R3");               // 0 - 1
        issue(r_ins(1, 1, 9, 34), 1, "R3");
        issue(r_ins(7, 6, 18, 34), 1, "R3");              // wraps to 0x7FFFFFFF
        issue(r_ins(2, 6, 10, 42), 1, "R4");              // -1 < 1
        issue(r_ins(6, 2, 11, 42), 1, "R4");
        issue(r_ins(7, 5, 12, 42), 1, "R4");              // most negative < most positive
        issue(r_ins(6, 6, 19, 42), 1, "R4");              // equal gives 0
        issue(i_ins(10, 2, 13, 16'h0000), 1, "R6");
        issue(i_ins(10, 6, 14, 16'hFFFB), 1, "R6");       // 1 < -5 is false
        issue(i_ins(10, 8, 20, 16'h0005), 1, "R6");
        issue(i_ins(12, 2, 15, 16'h8F0F), 1, "R7");
        issue(i_ins(12, 1, 21, 16'hFFFF), 1, "R7");
        issue(i_ins(13, 0, 16, 16'hFFFF), 1, "R8");
        issue(i_ins(8, 5, 22, 16'h0001), 1, "R5");        // wraps past max positive

        // R1: writes to index 0 vanish
        issue(r_ins(1, 2, 0, 32), 1, "R1");
        issue(i_ins(8, 1, 0, 16'h0005), 1, "R1");
        issue(i_ins(15, 0, 0, 16'hABCD), 1, "R1");

        // R10: ignored encodings and idle strobe
        issue(i_ins(35, 2, 1, 16'h0004), 1, "R10");
        issue(r_ins(2, 3, 1, 37), 1, "R10");
        issue(i_ins(8, 2, 1, 16'h0010), 0, "R10");
        issue(i_ins(63, 0, 4, 16'hFFFF), 1, "R10");

        // R11: dependent chain, each step reads the previous result
        issue(i_ins(8, 0, 17, 16'h0001), 1, "R11");
        for (int k = 0; k < 5; k++) issue(r_ins(17, 17, 17, 32), 1, "R11");

        drain();
        // R12: sweep the debug port over every register
        for (int i = 0; i < 32; i++) expect_reg(5'(i), "R12");
        drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule